// File: doc/BRIEF.md
# Scalar Double-Precision Maximum Unit

This unit picks the larger of two IEEE-754 binary64 values and writes the winner into the low 64-bit lane of a 256-bit destination word. It is meant to sit in a vector execution pipeline behind operand read. The caller presents a 128-bit first source vector (`src_a`), whose low lane is the first operand. It also presents a 64-bit second operand (`src_b`), the current contents of the destination register (`dst_prev`), a mode bit and a valid strobe. One clock later the unit returns the merged destination word, a result-valid strobe, and two status flags.

The selection is deliberately asymmetric. Whenever the two values tie as zeros, or either value is a NaN, the unit returns the second operand exactly as given. It does not quieten it or change its sign. The first operand wins only when it is strictly greater. As a result, swapping the operands can change the result, unlike a symmetric maximum. Lane 1 (bits 127:64) always comes from `src_a`. The upper half either keeps `dst_prev` (legacy mode) or is cleared (vector-extension mode).

A two-state output sequencer drives the strobe. **ST_IDLE** means no result is being presented. **ST_EMIT** means the registered result is new this cycle. The transition ST_IDLE→ST_EMIT and the loop ST_EMIT→ST_EMIT happen on `in_valid = 1`. The transitions ST_EMIT→ST_IDLE and ST_IDLE→ST_IDLE happen on `in_valid = 0`. Reset enters ST_IDLE.

Top module: `dmax_unit`

## Requirements
- R1: When both operands are zero (sign bit either value, exponent and fraction all zero), bits 63:0 of the result equal `src_b` bit for bit, so its sign is kept.
- R2: When either operand is a NaN (exponent bits 62:52 all ones, fraction bits 51:0 non-zero), bits 63:0 of the result equal `src_b` exactly; a signaling NaN (fraction bit 51 clear) in `src_b` is returned without setting bit 51.
- R3: Otherwise bits 63:0 hold `src_a[63:0]` only when it is strictly greater than `src_b`; equal values return `src_b`.
- R4: For non-NaN values of differing sign, the positive one is larger; when both are negative, the one with the smaller raw magnitude (bits 62:0) is larger.
- R5: Positive infinity (7FF0000000000000) beats every finite value, and negative infinity (FFF0000000000000) loses to every finite value.
- R6: Bits 127:64 of the result equal `src_a[127:64]`.
- R7: With `mode_vex = 0`, bits 255:128 of the result equal `dst_prev[255:128]`; with `mode_vex = 1`, they are zero.
- R8: `flag_invalid` is 1 for a result exactly when either operand is a NaN, quiet or signaling.
- R9: `flag_denorm` is 1 for a result exactly when either operand is subnormal (exponent zero, fraction non-zero).
- R10: `out_valid` is `in_valid` delayed by one clock; while `in_valid` is 0, `dst_out` and both flags hold their last value.
- R11: During and right after reset, `out_valid`, `dst_out`, `flag_invalid` and `flag_denorm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| mode_vex | input | 1 | 1: clear upper half; 0: keep `dst_prev` upper half |
| src_a | input | 128 | First source vector; low lane is the first operand |
| src_b | input | 64 | Second operand |
| dst_prev | input | 256 | Current destination register contents |
| out_valid | output | 1 | Result presented this cycle |
| dst_out | output | 256 | Merged destination word |
| flag_invalid | output | 1 | An operand was a NaN |
| flag_denorm | output | 1 | An operand was subnormal |

## Verification
A fault in the sequencer state shows at the ports on the very next clock. Either `out_valid` appears without a preceding request, or `out_valid` is missing after one, and the scoreboard then runs out of entries or keeps one unused. A wrong internal classification shows up in the same cycle as the result. A NaN or zero misread flips the chosen operand or the invalid flag. A sign-ordering fault in the comparator shows only for mixed-sign or both-negative pairs, so those pairs are driven on purpose. A stream of pseudo-random values covers the remaining ordering cases against a reference built on real-number comparison.

// File: rtl/dmax_pkg.sv
package dmax_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic is_zero;
        logic is_sub;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_t;
endpackage

// File: rtl/dmax_classify.sv
module dmax_classify
    import dmax_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] val,
    output fp_class_t      cls
);
    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_ones;
    logic          exp_zero;
    logic          frac_zero;

    always_comb begin
        exp_f     = val[EW+FW-1:FW];
        frac_f    = val[FW-1:0];
        exp_ones  = &exp_f;
        exp_zero  = ~|exp_f;
        frac_zero = ~|frac_f;
        cls.is_zero = exp_zero & frac_zero;
        cls.is_sub  = exp_zero & ~frac_zero;
        cls.is_inf  = exp_ones & frac_zero;
        cls.is_nan  = exp_ones & ~frac_zero;
        cls.is_snan = exp_ones & ~frac_zero & ~frac_f[FW-1];
    end
endmodule

// File: rtl/dmax_select.sv
module dmax_select
    import dmax_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  fp_class_t    cls_a,
    input  fp_class_t    cls_b,
    output logic [W-1:0] res,
    output logic         pick_a
);
    logic         sign_a;
    logic         sign_b;
    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         a_gt_b;
    logic         b_wins_forced;

    always_comb begin
        sign_a = op_a[W-1];
        sign_b = op_b[W-1];
        mag_a  = op_a[W-2:0];
        mag_b  = op_b[W-2:0];

        // Magnitude ordering on sign-magnitude encoding (infinities included).
        unique case ({sign_a, sign_b})
            2'b00:   a_gt_b = (mag_a > mag_b);
            2'b11:   a_gt_b = (mag_a < mag_b);
            2'b01:   a_gt_b = 1'b1;
            default: a_gt_b = 1'b0;
        endcase

        // Priority: zero pair, then any NaN, force the second operand.
        b_wins_forced = (cls_a.is_zero & cls_b.is_zero) | cls_a.is_nan | cls_b.is_nan;
        pick_a        = ~b_wins_forced & a_gt_b;
        res           = pick_a ? op_a : op_b;
    end
endmodule

// File: rtl/dmax_merge.sv
module dmax_merge #(
    parameter int LANE_W = 64,
    parameter int SRC_W  = 128,
    parameter int VEC_W  = 256
) (
    input  logic [LANE_W-1:0] low_lane,
    input  logic [SRC_W-1:0]  src_vec,
    input  logic [VEC_W-1:0]  prev_vec,
    input  logic              clear_hi,
    output logic [VEC_W-1:0]  merged
);
    localparam int N_LANES   = VEC_W / LANE_W;
    localparam int SRC_LANES = SRC_W / LANE_W;

    for (genvar li = 0; li < N_LANES; li++) begin : g_lane
        if (li == 0) begin : g_low
            assign merged[LANE_W-1:0] = low_lane;
        end else if (li < SRC_LANES) begin : g_src
            assign merged[li*LANE_W +: LANE_W] = src_vec[li*LANE_W +: LANE_W];
        end else begin : g_hi
            assign merged[li*LANE_W +: LANE_W] =
                clear_hi ? '0 : prev_vec[li*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/dmax_unit.sv
module dmax_unit
    import dmax_pkg::*;
#(
    parameter int LANE_W = WORD_W,
    parameter int SRC_W  = 2 * LANE_W,
    parameter int VEC_W  = 4 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode_vex,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [LANE_W-1:0] src_b,
    input  logic [VEC_W-1:0]  dst_prev,
    output logic              out_valid,
    output logic [VEC_W-1:0]  dst_out,
    output logic              flag_invalid,
    output logic              flag_denorm
);
    fp_class_t         cls_a;
    fp_class_t         cls_b;
    logic [LANE_W-1:0] sel_res;
    logic              sel_pick_a;
    logic [VEC_W-1:0]  merged;
    out_state_t        st_q;
    out_state_t        st_d;
    logic              inv_d;
    logic              den_d;

    dmax_classify u_cls_a (.val(src_a[LANE_W-1:0]), .cls(cls_a));
    dmax_classify u_cls_b (.val(src_b),             .cls(cls_b));

    dmax_select #(.W(LANE_W)) u_sel (
        .op_a  (src_a[LANE_W-1:0]),
        .op_b  (src_b),
        .cls_a (cls_a),
        .cls_b (cls_b),
        .res   (sel_res),
        .pick_a(sel_pick_a)
    );

    dmax_merge #(.LANE_W(LANE_W), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_merge (
        .low_lane(sel_res),
        .src_vec (src_a),
        .prev_vec(dst_prev),
        .clear_hi(mode_vex),
        .merged  (merged)
    );

    always_comb begin
        inv_d = cls_a.is_nan | cls_b.is_nan;
        den_d = cls_a.is_sub | cls_b.is_sub;
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = in_valid ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_out      <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else if (in_valid) begin
            dst_out      <= merged;
            flag_invalid <= inv_d;
            flag_denorm  <= den_d;
        end
    end

    assign out_valid = (st_q == ST_EMIT);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst_out) && $stable(flag_invalid));
    // R7
    vex_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_vex) |=> (dst_out[VEC_W-1:SRC_W] == '0));
    // R7
    legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_vex) |=> (dst_out[VEC_W-1:SRC_W] == $past(dst_prev[VEC_W-1:SRC_W])));
    // R6
    mid_lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dst_out[SRC_W-1:LANE_W] == $past(src_a[SRC_W-1:LANE_W])));
    // R2
    nan_pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls_a.is_nan || cls_b.is_nan)) |=> (dst_out[LANE_W-1:0] == $past(src_b)));
    // R1
    zero_pick_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls_a.is_zero && cls_b.is_zero) |=> (dst_out[LANE_W-1:0] == $past(src_b)));
    // R8
    invalid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_invalid == $past(cls_a.is_nan || cls_b.is_nan)));
    // R9
    denorm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_denorm == $past(cls_a.is_sub || cls_b.is_sub)));
endmodule

// File: tb/dmax_unit_bench.sv
module dmax_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode_vex = 1'b0;
    logic [127:0] src_a = '0;
    logic [63:0]  src_b = '0;
    logic [255:0] dst_prev = '0;
    logic         out_valid;
    logic [255:0] dst_out;
    logic         flag_invalid;
    logic         flag_denorm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [255:0] q_dst[$];
    logic         q_inv[$];
    logic         q_den[$];
    string        q_tag[$];
    logic [255:0] last_dst = '0;
    logic         last_inv = 1'b0;
    logic         last_den = 1'b0;
    logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] NSNAN  = 64'hFFF0_0000_0000_0005;
    localparam logic [63:0] SUBN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] NSUBN  = 64'h800F_FFFF_FFFF_FFFF;
    localparam logic [63:0] MAXF   = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] NMAXF  = 64'hFFEF_FFFF_FFFF_FFFF;

    dmax_unit u_dmax_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_vex(mode_vex),
        .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
        .out_valid(out_valid), .dst_out(dst_out),
        .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic bit is_sub(input logic [63:0] v);
        return (v[62:52] == 11'h000) && (v[51:0] != 0);
    endfunction

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Driver: reference model built from the requirements, result pushed to scoreboard
    task automatic drive(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input bit vex);
        logic [63:0]  hi_a;
        logic [255:0] prev;
        logic [63:0]  low;
        logic [255:0] exp_v;
        hi_a = next_rand();
        prev = {next_rand(), next_rand(), next_rand(), next_rand()};
        if (is_nan(a) || is_nan(b))                  low = b;
        else if ($bitstoreal(a) > $bitstoreal(b))    low = a;
        else                                         low = b;
        exp_v = {vex ? 128'h0 : prev[255:128], hi_a, low};
        @(negedge clk);
        in_valid = 1'b1;
        mode_vex = vex;
        src_a    = {hi_a, a};
        src_b    = b;
        dst_prev = prev;
        q_dst.push_back(exp_v);
        q_inv.push_back(is_nan(a) || is_nan(b));
        q_den.push_back(is_sub(a) || is_sub(b));
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a    = {next_rand(), next_rand()};
            src_b    = QNAN;
            dst_prev = '1;
        end
    endtask

    // Monitor: samples shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                if (out_valid) begin
                    if (q_dst.size() == 0) begin
                        n_tests++; n_fail++;
                        $display("FAIL R10 actual=unexpected out_valid expected=no result");
                    end else begin
                        string t;
                        logic [255:0] e;
                        logic ei;
                        logic ed;
                        t  = q_tag.pop_front();
                        e  = q_dst.pop_front();
                        ei = q_inv.pop_front();
                        ed = q_den.pop_front();
                        check(t, dst_out, e);
                        check({t, " R8"}, {255'h0, flag_invalid}, {255'h0, ei});
                        check({t, " R9"}, {255'h0, flag_denorm}, {255'h0, ed});
                        last_dst = e; last_inv = ei; last_den = ed;
                    end
                end else begin
                    // R10: hold while idle
                    check("R10 hold", {dst_out[253:0], flag_invalid, flag_denorm},
                          {last_dst[253:0], last_inv, last_den});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {dst_out[252:0], out_valid, flag_invalid, flag_denorm}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {dst_out[252:0], out_valid, flag_invalid, flag_denorm}, '0);

        drive("R1 +0,-0", P_ZERO, N_ZERO, 1'b0);
        drive("R1 -0,+0", N_ZERO, P_ZERO, 1'b1);
        drive("R1 -0,-0", N_ZERO, N_ZERO, 1'b0);
        idle(2);
        drive("R2 snan b", P_ONE, SNAN, 1'b0);
        drive("R2 snan a", SNAN, P_ONE, 1'b0);
        drive("R2 qnan a", QNAN, N_INF, 1'b1);
        drive("R2 qnan b", MAXF, QNAN, 1'b0);
        drive("R2 neg snan b", QNAN, NSNAN, 1'b1);
        drive("R3 a>b", P_TWO, P_ONE, 1'b0);
        drive("R3 a<b", P_ONE, P_TWO, 1'b0);
        drive("R3 equal", N_TWO, N_TWO, 1'b1);
        drive("R4 pos vs neg", P_ONE, N_TWO, 1'b0);
        drive("R4 neg vs pos", N_ONE, SUBN, 1'b0);
        drive("R4 both neg", N_ONE, N_TWO, 1'b1);
        drive("R4 both neg rev", N_TWO, N_ONE, 1'b0);
        drive("R5 +inf", P_INF, MAXF, 1'b0);
        drive("R5 -inf", NMAXF, N_INF, 1'b0);
        drive("R5 -inf a", N_INF, NMAXF, 1'b1);
        drive("R9 subnormal", SUBN, P_ZERO, 1'b0);
        drive("R9 neg subnormal", N_ONE, NSUBN, 1'b1);
        idle(3);
        drive("R6 R7 legacy", P_ONE, N_ONE, 1'b0);
        drive("R6 R7 vex", P_ONE, N_ONE, 1'b1);
        idle(1);
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra;
            logic [63:0] rb;
            ra = next_rand();
            rb = next_rand();
            if (i % 7 == 0) rb = {rb[63], ra[62:0]};
            if (i % 11 == 0) ra[62:52] = 11'h0;
            drive("R3 R4 random", ra, rb, i[0]);
            if (i % 5 == 0) idle(1);
        end
        idle(3);
        done = 1;
        if (q_dst.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R10 actual=%0d pending expected=0", q_dst.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule